// File: doc/BRIEF.md
# Sparse-Tree Parallel-Prefix Binary Adder

This block adds two unsigned binary words and a carry-in, giving a word-wide sum and a carry-out. It is built to serve as the significand adder of a fused multiply-add datapath. Any operand inversion needed for subtraction is done by the caller before the operands reach this block.

Carries come from a sparse parallel-prefix network. Each bit first forms a generate and a propagate signal, and the carry-in is folded into the generate of bit 0. A doubling-span tree then combines (generate, propagate) pairs at odd bit positions only. A single extra level at the end fills in each even position from the odd prefix just below it. For a 32-bit word this takes log2(32)+1 = 6 combine levels. The tree uses fewer prefix cells than a dense doubling tree and avoids the long fan-out wires of a minimal-cell tree. A parameter selects whether the result is captured in output registers (one cycle of latency) or driven straight from the logic.

Top module: `hc_prefix_adder`

## Requirements
- R1: With REGISTERED=1, `sum` equals the low WIDTH bits of a + b + cin, taken from the inputs sampled at the previous rising clock edge.
- R2: `cout` equals bit WIDTH (the carry out of the most significant bit) of the same a + b + cin.
- R3: The carry out of every bit position i, as produced by the prefix network, equals the carry that ripple addition of bits 0..i of a, b and cin would produce.
- R4: All-ones plus zero with cin=1 gives `sum` = 0 and `cout` = 1.
- R5: With REGISTERED=1, a rising edge with `rst_n` low sets `sum` and `cout` to 0, whatever the inputs.
- R6: b = 0 with cin = 0 gives `sum` = a and `cout` = 0.
- R7: With REGISTERED=0, `sum` and `cout` follow the inputs in the same cycle, with no clock edge in between.
- R8: Operands whose bits all propagate (a = 0xAAAA_AAAA, b = 0x5555_5555) with cin=1 send the carry through every position: `sum` = 0 and `cout` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output registers |
| rst_n | input | 1 | Synchronous active-low reset of the output registers |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry-in into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
The bench builds two instances.

- **32-bit registered instance.** WIDTH=32 with REGISTERED=1 gives the full six-level tree. This lets the bench reach propagate chains that cross all five sparse spans and the even-position fill level. It also covers the one-cycle latency and the reset clearing.
- **16-bit combinational instance.** WIDTH=16 with REGISTERED=0 checks that the tree depth scales with the parameter (four sparse levels) and that the unregistered path settles within the same cycle.

The same random and corner-case vectors feed both instances.

// File: rtl/hc_adder_pkg.sv
// Package: shared types and the prefix combine operator for the sparse adder.
// Assumes: callers combine a more significant group (hi) with the group
// directly below it (lo).
package hc_adder_pkg;

    typedef struct packed {
        logic g;   // group generate
        logic p;   // group propagate
    } gp_t;

    // Associative prefix operator: (hi) o (lo).
    function automatic gp_t gp_combine(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/hc_gp_precompute.sv
// Module: per-bit generate/propagate formation.
// Does: g = a & b, p = a ^ b for each bit. The carry-in is folded into bit 0's
// generate, so the tree needs no separate carry-in input.
// Assumes: nothing beyond WIDTH >= 2.
module hc_gp_precompute
    import hc_adder_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             c_in,
    output gp_t  [WIDTH-1:0] bit_gp
);

    // Form bitwise pairs; bit 0 absorbs the carry-in.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            bit_gp[i].g = op_a[i] & op_b[i];
            bit_gp[i].p = op_a[i] ^ op_b[i];
        end
        bit_gp[0].g = (op_a[0] & op_b[0]) | ((op_a[0] ^ op_b[0]) & c_in);
    end

endmodule

// File: rtl/hc_prefix_tree.sv
// Module: sparse parallel-prefix carry network.
// Does: log2(WIDTH) doubling-span levels over odd positions only, then one
// fill level that completes the even positions from the odd prefix below.
// Output grp_g[i] is the carry out of bit i.
// Assumes: WIDTH is a power of two, >= 2.
module hc_prefix_tree
    import hc_adder_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  gp_t  [WIDTH-1:0] bit_gp,
    output logic [WIDTH-1:0] grp_g
);

    localparam int SPARSE_LVLS = $clog2(WIDTH);

    gp_t [WIDTH-1:0] lvl [0:SPARSE_LVLS];

    assign lvl[0] = bit_gp;

    // Sparse levels: odd positions reach back SPAN bits; others pass through.
    for (genvar k = 1; k <= SPARSE_LVLS; k++) begin : g_lvl
        localparam int SPAN = 1 << (k - 1);
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            if ((i % 2 == 1) && (i >= SPAN)) begin : g_cell
                assign lvl[k][i] = gp_combine(lvl[k-1][i], lvl[k-1][i-SPAN]);
            end else begin : g_wire
                assign lvl[k][i] = lvl[k-1][i];
            end
        end
    end

    // Fill level: even positions take the finished prefix of the odd bit below.
    for (genvar i = 0; i < WIDTH; i++) begin : g_fill
        if ((i % 2 == 1) || (i == 0)) begin : g_done
            assign grp_g[i] = lvl[SPARSE_LVLS][i].g;
        end else begin : g_even
            assign grp_g[i] = lvl[SPARSE_LVLS][i].g
                            | (lvl[SPARSE_LVLS][i].p & lvl[SPARSE_LVLS][i-1].g);
        end
    end

endmodule

// File: rtl/hc_sum_logic.sv
// Module: final sum formation.
// Does: sum[i] = p[i] ^ carry-into-bit-i, where the carry into bit 0 is cin
// and the carry into bit i>0 is grp_g[i-1]. Carry-out is the group generate
// of the whole word.
// Assumes: bit_gp[0].p is the raw a0^b0 (carry-in not folded into p).
module hc_sum_logic
    import hc_adder_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  gp_t  [WIDTH-1:0] bit_gp,
    input  logic [WIDTH-1:0] grp_g,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum_raw,
    output logic             cout_raw
);

    logic [WIDTH-1:0] carry_into;

    // Shift group carries up one place and insert the carry-in at bit 0.
    assign carry_into = {grp_g[WIDTH-2:0], c_in};

    // XOR each propagate with its incoming carry.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            sum_raw[i] = bit_gp[i].p ^ carry_into[i];
        end
    end

    assign cout_raw = grp_g[WIDTH-1];

endmodule

// File: rtl/hc_prefix_adder.sv
// Module: top of the sparse parallel-prefix adder.
// Does: precompute -> prefix tree -> sum logic. With REGISTERED=1 the result
// is captured in output flops (synchronous active-low reset); otherwise it is
// driven combinationally.
// Assumes: WIDTH is a power of two, >= 2. Subtraction inversion is done
// by the caller.
module hc_prefix_adder
    import hc_adder_pkg::*;
#(
    parameter int WIDTH      = 32,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    gp_t  [WIDTH-1:0] bit_gp;
    logic [WIDTH-1:0] grp_g;
    logic [WIDTH-1:0] sum_raw;
    logic             cout_raw;

    hc_gp_precompute #(.WIDTH(WIDTH)) u_pre (
        .op_a   (a),
        .op_b   (b),
        .c_in   (cin),
        .bit_gp (bit_gp)
    );

    hc_prefix_tree #(.WIDTH(WIDTH)) u_tree (
        .bit_gp (bit_gp),
        .grp_g  (grp_g)
    );

    hc_sum_logic #(.WIDTH(WIDTH)) u_sum (
        .bit_gp   (bit_gp),
        .grp_g    (grp_g),
        .c_in     (cin),
        .sum_raw  (sum_raw),
        .cout_raw (cout_raw)
    );

    // Behavioural reference used only by the assertions below.
    logic [WIDTH:0] ref_total;
    logic [WIDTH:0] ref_carry;
    assign ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    assign ref_carry = ref_total ^ {1'b0, a ^ b};

    // R3: every tree carry matches the ripple reference.
    a_r3_carry_vector: assert property (@(posedge clk) disable iff (!rst_n)
        grp_g == ref_carry[WIDTH:1]);

    if (REGISTERED) begin : g_reg
        // Capture the result; clear on synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum  <= '0;
                cout <= 1'b0;
            end else begin
                sum  <= sum_raw;
                cout <= cout_raw;
            end
        end

        // R1: registered sum equals the previous cycle's a+b+cin.
        a_r1_sum_value: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> sum == $past(ref_total[WIDTH-1:0]));

        // R2: registered carry-out equals the top bit of the previous total.
        a_r2_carry_out: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> cout == $past(ref_total[WIDTH]));

        // R5: the first edge after reset still shows the cleared outputs.
        a_r5_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (sum == '0) && !cout);

        // R6: adding zero returns the other operand with no carry.
        a_r6_identity: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(b) == '0) && !$past(cin))
                |-> (sum == $past(a)) && !cout);
    end else begin : g_comb
        assign sum  = sum_raw;
        assign cout = cout_raw;

        // R7: unregistered outputs match the same-cycle total.
        a_r7_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            {cout, sum} == ref_total);
    end

endmodule

// File: tb/hc_prefix_adder_tb.sv
module hc_prefix_adder_tb;

    localparam int W  = 32;
    localparam int WC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  a = '0, b = '0;
    logic          cin = 1'b0;
    logic [W-1:0]  sum;
    logic          cout;
    logic [WC-1:0] a16 = '0, b16 = '0;
    logic [WC-1:0] sum16;
    logic          cout16;

    int n_checks = 0;
    int n_fail   = 0;

    logic [W:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;   // 125 MHz

    hc_prefix_adder #(.WIDTH(W), .REGISTERED(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin),
        .sum(sum), .cout(cout));

    hc_prefix_adder #(.WIDTH(WC), .REGISTERED(1'b0)) u_dut_comb (
        .clk(clk), .rst_n(rst_n), .a(a16), .b(b16), .cin(cin),
        .sum(sum16), .cout(cout16));

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    endtask

    // Driver: apply a vector, queue its expected result, check the comb copy.
    task automatic drive(input logic [W-1:0] va, input logic [W-1:0] vb,
                         input logic vc, input string tag);
        logic [WC:0] e16;
        @(negedge clk);
        a = va; b = vb; cin = vc;
        a16 = va[WC-1:0]; b16 = vb[WC-1:0];
        exp_q.push_back({1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc});
        tag_q.push_back(tag);
        e16 = {1'b0, va[WC-1:0]} + {1'b0, vb[WC-1:0]} + {{WC{1'b0}}, vc};
        #1;
        check("R7", {47'd0, cout16, sum16}, {47'd0, e16});
    endtask

    // Monitor: compare registered outputs with the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [W:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t,    {32'd0, sum},       {32'd0, e[W-1:0]});
                check("R2", {63'd0, cout},      {63'd0, e[W]});
            end
        end
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        a = 32'hFFFF_FFFF; b = 32'h1234_5678; cin = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R5", {31'd0, cout, sum}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);

        drive(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R4");
        drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R4");
        drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R8");
        drive(32'h5555_5555, 32'hAAAA_AAAA, 1'b0, "R8");
        drive(32'hDEAD_BEEF, 32'h0000_0000, 1'b0, "R6");
        drive(32'h0000_0000, 32'h0000_0000, 1'b0, "R6");
        drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R1");
        drive(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, "R3");
        drive(32'h0000_FFFF, 32'h0000_0001, 1'b0, "R3");
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R1");
        for (int k = 0; k < 2000; k++) begin
            drive($urandom, $urandom, 1'($urandom), "R1");
        end
        repeat (3) @(posedge clk);

        // Mid-run reset with nonzero inputs held.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R5", {31'd0, cout, sum}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        finish_run();
    end

endmodule